// File: doc/BRIEF.md
# Monotonic Microsecond Time-of-Day Counter

This block keeps a 52-bit count of microseconds since a fixed epoch. The count advances by one on each pulse of a microsecond tick input. The block sits on a simple word-wide bus as a passive device. It answers reads of the current time and accepts writes that set the time or set an alarm point.

Every time reading it returns is unique. If a caller reads again before the count has moved past the value last handed out, the block returns that value plus one. The returned value may therefore run ahead of the count for a short while, until enough ticks arrive for the count to overtake it. A 36-bit bus cannot carry the whole value, so a reading comes back as two words. Reading the low word captures the matching high word, and a later high-word read returns that captured word.

The alarm is a three-state machine:
- `AL_IDLE`: no alarm is set.
- `AL_ARMED`: waiting for the count to reach the alarm point.
- `AL_RINGING`: the interrupt is raised.

The transitions are:
- Writing an alarm point (`AL_IDLE`→`AL_ARMED`, `AL_ARMED`→`AL_ARMED`, `AL_RINGING`→`AL_ARMED`).
- The count reaching the alarm point (`AL_ARMED`→`AL_RINGING`).
- An acknowledge write (`AL_RINGING`→`AL_IDLE`).

Top module: `ccal_clock`

## Requirements
- R1: After reset the count is 0, `alarm_irq` is 0 and `bus_rvalid` is 0, and the first low-word read returns 0.
- R2: Each cycle with `us_tick` high and no time load adds one to the count. A low-word read (address 0) returns bits 35:0 of the reading, and the next high-word read (address 1) returns bits 51:36 in bus bits 15:0 with zeros above.
- R3: A low-word read made while the count is not beyond the last returned value returns the last returned value plus one, so back-to-back reads give strictly increasing values.
- R4: Once the count exceeds the last returned value, a read returns the count itself.
- R5: A high-word read returns the high bits captured at the most recent low-word read. Ticks or a carry into bit 36 in between do not change it.
- R6: Writing address 2 stages bits 35:0 of a new time. Writing address 3 loads the time, taking bits 51:36 from bus bits 15:0 and the rest from the staged word. The load also clears the uniqueness history, so the next read returns the loaded value even if it is below earlier readings.
- R7: The count and the readings wrap modulo 2^52.
- R8: Writing address 4 stages the low alarm word. Writing address 5 commits the alarm point, with its high bits in bus bits 15:0. `alarm_irq` rises within two cycles once the count is greater than or equal to the alarm point, and it stays high until acknowledged.
- R9: A write to address 6 while ringing drops `alarm_irq` the next cycle. The same alarm point does not fire again, even though the count remains past it.
- R10: Committing a new alarm point while ringing drops `alarm_irq` at once and re-arms on the new point.
- R11: Every read gets `bus_rvalid` high with data in the following cycle. Reads of addresses 2 to 7 return 0. Writes never raise `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| bus_sel | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 36 | Write data |
| bus_rdata | output | 36 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read response strobe |
| alarm_irq | output | 1 | Alarm interrupt, level |

## Verification
The assertions assume at most one bus request per cycle. They also assume that a time load and a read never fall in the same cycle, and that an acknowledge only means something while ringing. The bench issues every bus operation as a single-cycle request from one sequential task, so overlap cannot occur. It pulses the tick only between requests, which keeps the model's ordering of ticks and reads identical to the design's.

// File: rtl/ccal_pkg.sv
package ccal_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RD_LO   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RD_HI   = 3'd1;
    localparam logic [ADDR_W-1:0] A_TSTAGE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TLOAD   = 3'd3;
    localparam logic [ADDR_W-1:0] A_ASTAGE  = 3'd4;
    localparam logic [ADDR_W-1:0] A_ACOMMIT = 3'd5;
    localparam logic [ADDR_W-1:0] A_ACK     = 3'd6;

    typedef enum logic [1:0] {
        AL_IDLE    = 2'd0,
        AL_ARMED   = 2'd1,
        AL_RINGING = 2'd2
    } alarm_state_e;
endpackage

// File: rtl/ccal_counter.sv
module ccal_counter #(
    parameter int TIME_W = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] now
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '0;
        end else if (load) begin
            now <= load_val;
        end else if (tick) begin
            now <= now + TIME_W'(1);
        end
    end

    // R2 and R7: a tick adds exactly one, wrapping at the width
    a_r2_tick_increments: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load |=> now == $past(now) + TIME_W'(1));

    // R6: a load wins over a tick
    a_r6_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> now == $past(load_val));
endmodule

// File: rtl/ccal_unique.sv
module ccal_unique #(
    parameter int TIME_W = 52,
    parameter int BUS_W  = 36
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TIME_W-1:0]       now,
    input  logic                    rd_lo,
    input  logic                    clear,
    output logic [TIME_W-1:0]       rd_val,
    output logic [TIME_W-BUS_W-1:0] hi_held
);
    localparam int HI_W = TIME_W - BUS_W;

    logic [TIME_W-1:0] ret_last;
    logic              have_ret;
    logic [TIME_W-1:0] gap;
    logic              behind;

    always_comb begin
        gap    = now - ret_last;
        behind = have_ret && ((gap == '0) || gap[TIME_W-1]);
        rd_val = behind ? ret_last + TIME_W'(1) : now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_last <= '0;
            have_ret <= 1'b0;
            hi_held  <= '0;
        end else if (clear) begin
            have_ret <= 1'b0;
        end else if (rd_lo) begin
            ret_last <= rd_val;
            have_ret <= 1'b1;
            hi_held  <= rd_val[TIME_W-1 -: HI_W];
        end
    end

    // R3: consecutive readings never repeat
    a_r3_reading_moves: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo && !clear && have_ret |=> ret_last != $past(ret_last));

    // R5: captured high word only changes on a low-word read
    a_r5_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo |=> $stable(hi_held));
endmodule

// File: rtl/ccal_alarm.sv
module ccal_alarm
    import ccal_pkg::*;
#(
    parameter int TIME_W = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              arm,
    input  logic [TIME_W-1:0] arm_val,
    input  logic              ack,
    output logic              irq
);
    alarm_state_e      state_q, state_d;
    logic [TIME_W-1:0] point;
    logic              reached;

    assign reached = (now >= point);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_IDLE:    if (arm) state_d = AL_ARMED;
            AL_ARMED:   if (arm) state_d = AL_ARMED;
                        else if (reached) state_d = AL_RINGING;
            AL_RINGING: if (arm) state_d = AL_ARMED;
                        else if (ack) state_d = AL_IDLE;
            default:    state_d = AL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AL_IDLE;
            point   <= '0;
        end else begin
            state_q <= state_d;
            if (arm) point <= arm_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (state_d == AL_RINGING);
    end

    // R9: acknowledge drops the interrupt
    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ack && irq |=> !irq);

    // R10: a new alarm point drops the interrupt
    a_r10_rearm_drops: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !irq);

    // R8: interrupt only rises after the count has reached the point
    a_r8_rise_reached: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(reached));
endmodule

// File: rtl/ccal_clock.sv
module ccal_clock
    import ccal_pkg::*;
#(
    parameter int TIME_W = 52,
    parameter int BUS_W  = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    output logic              alarm_irq
);
    localparam int HI_W = TIME_W - BUS_W;

    logic              rd, wr, rd_lo, t_load, a_commit, a_ack;
    logic [BUS_W-1:0]  t_stage, a_stage;
    logic [TIME_W-1:0] now, rd_val, t_new, a_new;
    logic [HI_W-1:0]   hi_held;
    logic [BUS_W-1:0]  rd_mux;

    always_comb begin
        rd       = bus_sel && !bus_we;
        wr       = bus_sel && bus_we;
        rd_lo    = rd && (bus_addr == A_RD_LO);
        t_load   = wr && (bus_addr == A_TLOAD);
        a_commit = wr && (bus_addr == A_ACOMMIT);
        a_ack    = wr && (bus_addr == A_ACK);
        t_new    = {bus_wdata[HI_W-1:0], t_stage};
        a_new    = {bus_wdata[HI_W-1:0], a_stage};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_stage <= '0;
            a_stage <= '0;
        end else if (wr) begin
            if (bus_addr == A_TSTAGE) t_stage <= bus_wdata;
            if (bus_addr == A_ASTAGE) a_stage <= bus_wdata;
        end
    end

    ccal_counter #(.TIME_W(TIME_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .load(t_load),
        .load_val(t_new), .now(now)
    );

    ccal_unique #(.TIME_W(TIME_W), .BUS_W(BUS_W)) u_uniq (
        .clk(clk), .rst_n(rst_n), .now(now), .rd_lo(rd_lo), .clear(t_load),
        .rd_val(rd_val), .hi_held(hi_held)
    );

    ccal_alarm #(.TIME_W(TIME_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .now(now), .arm(a_commit),
        .arm_val(a_new), .ack(a_ack), .irq(alarm_irq)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_RD_LO)      rd_mux = rd_val[BUS_W-1:0];
        else if (bus_addr == A_RD_HI) rd_mux = {{(BUS_W-HI_W){1'b0}}, hi_held};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd;
            bus_rdata  <= rd ? rd_mux : '0;
        end
    end

    // R11: every read is answered next cycle, writes never are
    a_r11_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);
    a_r11_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !bus_rvalid);
endmodule

// File: tb/test_ccal_clock.sv
module test_ccal_clock;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [35:0] bus_wdata = '0;
    logic [35:0] bus_rdata;
    logic        bus_rvalid;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;

    logic [35:0] exp_q[$];
    string       tag_q[$];

    logic [51:0] m_now = '0, m_last = '0;
    logic        m_have = 1'b0;
    logic [15:0] m_hi = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccal_clock i_ccal_clock (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .alarm_irq(alarm_irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected response", 64'(bus_rdata), 64'd0);
            end else begin
                logic [35:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            m_now = m_now + 52'd1;
        end
    endtask

    task automatic bus_op(input bit we, input logic [2:0] a, input logic [35:0] d);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_lo(input string tag);
        logic [51:0] v;
        logic [51:0] g;
        g = m_now - m_last;
        v = (m_have && (g == 0 || g[51])) ? m_last + 52'd1 : m_now;
        m_last = v; m_have = 1'b1; m_hi = v[51:36];
        exp_q.push_back(v[35:0]); tag_q.push_back(tag);
        bus_op(1'b0, 3'd0, '0);
    endtask

    task automatic rd_hi(input string tag);
        exp_q.push_back({20'd0, m_hi}); tag_q.push_back(tag);
        bus_op(1'b0, 3'd1, '0);
    endtask

    task automatic set_time(input logic [51:0] v);
        bus_op(1'b1, 3'd2, v[35:0]);
        bus_op(1'b1, 3'd3, {20'd0, v[51:36]});
        m_now = v; m_have = 1'b0;
    endtask

    task automatic set_alarm(input logic [51:0] v);
        bus_op(1'b1, 3'd4, v[35:0]);
        bus_op(1'b1, 3'd5, {20'd0, v[51:36]});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "watchdog", 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check(alarm_irq === 1'b0, "R1 irq", 64'(alarm_irq), 0);
        check(bus_rvalid === 1'b0, "R1 rvalid", 64'(bus_rvalid), 0);
        rd_lo("R1 first read");
        rd_hi("R1 first high");
        // R2 counting
        tick(5);
        rd_lo("R2 count after ticks");
        rd_hi("R2 high word");
        // R3 repeated reads without ticks
        rd_lo("R3 second read");
        rd_lo("R3 third read");
        // R4 catch-up
        tick(1);
        rd_lo("R4 still ahead");
        tick(3);
        rd_lo("R4 count overtakes");
        // R6 load, then load below earlier readings
        set_time(52'hA_BCDE_F012_3456);
        check(bus_rvalid === 1'b0, "R11 write no response", 64'(bus_rvalid), 0);
        rd_lo("R6 loaded low");
        rd_hi("R6 loaded high");
        rd_lo("R3 after load");
        set_time(52'd3);
        rd_lo("R6 history cleared");
        // R5 carry between low and high read
        set_time(52'h0_000F_FFFF_FFFF);
        rd_lo("R5 low before carry");
        tick(1);
        rd_hi("R5 high held across carry");
        rd_lo("R5 low after carry");
        rd_hi("R5 high after carry");
        // R7 wrap
        set_time({52{1'b1}});
        tick(1);
        rd_lo("R7 count wrapped");
        rd_hi("R7 high wrapped");
        set_time({52{1'b1}});
        rd_lo("R7 max reading");
        rd_lo("R7 reading wraps");
        rd_hi("R7 high after wrap");
        // R8 alarm
        set_time(52'd100);
        set_alarm(52'd110);
        idle(2);
        check(alarm_irq === 1'b0, "R8 not yet", 64'(alarm_irq), 0);
        tick(9);
        idle(2);
        check(alarm_irq === 1'b0, "R8 one short", 64'(alarm_irq), 0);
        tick(1);
        idle(1);
        check(alarm_irq === 1'b1, "R8 fires at point", 64'(alarm_irq), 1);
        idle(5);
        check(alarm_irq === 1'b1, "R8 stays high", 64'(alarm_irq), 1);
        // R9 acknowledge
        bus_op(1'b1, 3'd6, '0);
        check(alarm_irq === 1'b0, "R9 ack drops", 64'(alarm_irq), 0);
        tick(5);
        idle(3);
        check(alarm_irq === 1'b0, "R9 no refire", 64'(alarm_irq), 0);
        // R8 point already passed
        set_alarm(52'd50);
        idle(2);
        check(alarm_irq === 1'b1, "R8 past point", 64'(alarm_irq), 1);
        // R10 re-arm while ringing
        set_alarm(52'd1000);
        check(alarm_irq === 1'b0, "R10 rearm drops", 64'(alarm_irq), 0);
        idle(3);
        check(alarm_irq === 1'b0, "R10 stays armed", 64'(alarm_irq), 0);
        // R11 other addresses read zero
        exp_q.push_back('0); tag_q.push_back("R11 addr 7");
        bus_op(1'b0, 3'd7, '0);
        exp_q.push_back('0); tag_q.push_back("R11 addr 2");
        bus_op(1'b0, 3'd2, '0);
        idle(3);
        check(exp_q.size() == 0, "R11 all answered", 64'(exp_q.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule